// File: doc/BRIEF.md
# Four-Channel One-Shot Alarm Unit

This block holds four alarm channels that watch the low 32 bits of a free-running timebase supplied from outside. Software writes a 32-bit target into a channel, and that write also arms the channel. When an armed channel's target matches the incoming time value exactly, the channel fires once and then disarms itself. Software can also cancel an armed channel before it fires.

Each firing sets a sticky raw interrupt bit. The raw bits pass through an enable mask and a software force to give the status bits, and each status bit drives its own interrupt line. All state is reached through a simple register bus: a write strobe, a byte address, write data, and combinational read data. A lock input blocks every register write while it is high.

Top module: `quad_alarm`

## Requirements
- R1: A write to a target register stores the 32-bit value and sets that channel's armed flag. The target register for channel n sits at byte offset 0x10 + 4*n, and it reads back the stored value.
- R2: An armed channel whose target equals `timeLo` on a clock edge fires on that edge. Firing sets raw bit n (offset 0x3C) and clears armed bit n (offset 0x20, bits 3:0), both visible after that edge.
- R3: An armed channel whose target differs from `timeLo` in any bit does not fire and stays armed.
- R4: Writing 1 to bit n of the armed register (offset 0x20) clears that channel's armed flag. A channel disarmed this way does not fire when its target is later reached. Writing 0 to a bit has no effect.
- R5: A raw bit stays set until software writes 1 to it at offset 0x3C. Because a channel disarms when it fires, a matching time that persists does not set the bit again.
- R6: Status (offset 0x48, read-only) bit n equals (raw[n] AND enable[n]) OR force[n]. Enable is at offset 0x40 and force at offset 0x44. `irqOut[n]` equals status bit n.
- R7: If a target write to channel n arrives on the same edge as a match on that channel, the write wins. The channel stays armed with the new target, and raw bit n is not set.
- R8: While `lockIn` is high, bus writes change no register: no target, armed, raw, enable or force state.
- R9: After reset, every register reads 0 and all interrupt lines are low. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| timeLo | input | 32 | Live low 32 bits of the timebase |
| busWrEn | input | 1 | Write strobe, one write per cycle |
| busAddr | input | 8 | Byte address for reads and writes |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| lockIn | input | 1 | Blocks all register writes while high |
| irqOut | output | 4 | Per-channel interrupt lines, equal to the status bits |

## Verification
The comparator is tried with a target that differs from the time only in the top bit, which separates a full-width compare from a truncated one. It is also tried with an exact match, with a match that persists after the channel fires, and with two channels sharing one target so they fire on the same edge. A target rewrite is placed on the very edge of a match to show that the write wins. A cancelled channel is then driven to its target time, which tells a real disarm apart from one that merely hides the flag. The interrupt path is tried with raw bits that are set but not enabled, with raw bits that are enabled, and with force applied while raw is clear, which separates the masking term from the force term.

// File: rtl/quad_alarm_pkg.sv
package quad_alarm_pkg;

  localparam int unsigned CH_COUNT = 4;
  localparam int unsigned DATA_W   = 32;

  // strobes handed from bus decode to the datapath
  typedef struct packed {
    logic [CH_COUNT-1:0] tgtWr;
    logic                armWr;
    logic                rawWr;
    logic                enWr;
    logic                frcWr;
    logic [DATA_W-1:0]   wrData;
  } qa_strobe_t;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_TGT  = 3'd1,
    SEL_ARM  = 3'd2,
    SEL_RAW  = 3'd3,
    SEL_EN   = 3'd4,
    SEL_FRC  = 3'd5,
    SEL_STAT = 3'd6
  } qa_rdsel_e;

endpackage

// File: rtl/quad_alarm_ctrl.sv
module quad_alarm_ctrl
  import quad_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned TGT_BASE = 'h10,
  parameter int unsigned ARM_OFS  = 'h20,
  parameter int unsigned RAW_OFS  = 'h3C,
  parameter int unsigned EN_OFS   = 'h44 - 4,
  parameter int unsigned FRC_OFS  = 'h44,
  parameter int unsigned STAT_OFS = 'h48,
  localparam int unsigned CH_IDX_W = (CH_COUNT > 1) ? $clog2(CH_COUNT) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic                lockIn,
  output qa_strobe_t          strobe,
  output qa_rdsel_e           rdSel,
  output logic [CH_IDX_W-1:0] rdCh
);

  logic                wrOk;
  logic [CH_COUNT-1:0] tgtHit;

  assign wrOk = busWrEn && !lockIn;

  for (genvar n = 0; n < CH_COUNT; n++) begin : g_tgtDec
    assign tgtHit[n] = (busAddr == ADDR_W'(TGT_BASE + 4*n));
  end

  always_comb begin
    strobe.tgtWr  = wrOk ? tgtHit : '0;
    strobe.armWr  = wrOk && (busAddr == ADDR_W'(ARM_OFS));
    strobe.rawWr  = wrOk && (busAddr == ADDR_W'(RAW_OFS));
    strobe.enWr   = wrOk && (busAddr == ADDR_W'(EN_OFS));
    strobe.frcWr  = wrOk && (busAddr == ADDR_W'(FRC_OFS));
    strobe.wrData = busWrData;
  end

  always_comb begin
    rdSel = SEL_NONE;
    rdCh  = '0;
    for (int n = 0; n < CH_COUNT; n++) begin
      if (tgtHit[n]) begin
        rdSel = SEL_TGT;
        rdCh  = CH_IDX_W'(n);
      end
    end
    if (busAddr == ADDR_W'(ARM_OFS))  rdSel = SEL_ARM;
    if (busAddr == ADDR_W'(RAW_OFS))  rdSel = SEL_RAW;
    if (busAddr == ADDR_W'(EN_OFS))   rdSel = SEL_EN;
    if (busAddr == ADDR_W'(FRC_OFS))  rdSel = SEL_FRC;
    if (busAddr == ADDR_W'(STAT_OFS)) rdSel = SEL_STAT;
  end

  // R8
  lock_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockIn |-> ($countones({strobe.tgtWr, strobe.armWr, strobe.rawWr,
                            strobe.enWr, strobe.frcWr}) == 0));

endmodule

// File: rtl/quad_alarm_dp.sv
module quad_alarm_dp
  import quad_alarm_pkg::*;
#(
  localparam int unsigned CH_IDX_W = (CH_COUNT > 1) ? $clog2(CH_COUNT) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   timeLo,
  input  qa_strobe_t          strobe,
  input  qa_rdsel_e           rdSel,
  input  logic [CH_IDX_W-1:0] rdCh,
  output logic [DATA_W-1:0]   rdData,
  output logic [CH_COUNT-1:0] irqOut
);

  logic [DATA_W-1:0]   targetQ [CH_COUNT];
  logic [CH_COUNT-1:0] armedQ;
  logic [CH_COUNT-1:0] rawQ;
  logic [CH_COUNT-1:0] enQ;
  logic [CH_COUNT-1:0] forceQ;
  logic [CH_COUNT-1:0] matchVec;
  logic [CH_COUNT-1:0] fireVec;
  logic [CH_COUNT-1:0] disarmVec;
  logic [CH_COUNT-1:0] rawClrVec;
  logic [CH_COUNT-1:0] statusVec;

  assign disarmVec = strobe.armWr ? strobe.wrData[CH_COUNT-1:0] : '0;
  assign rawClrVec = strobe.rawWr ? strobe.wrData[CH_COUNT-1:0] : '0;

  for (genvar n = 0; n < CH_COUNT; n++) begin : g_ch
    assign matchVec[n] = armedQ[n] && (targetQ[n] == timeLo);
    // a target write on the match edge wins over the match
    assign fireVec[n]  = matchVec[n] && !strobe.tgtWr[n];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        targetQ[n] <= '0;
        armedQ[n]  <= 1'b0;
        rawQ[n]    <= 1'b0;
      end else begin
        if (strobe.tgtWr[n]) targetQ[n] <= strobe.wrData;

        if (strobe.tgtWr[n])    armedQ[n] <= 1'b1;
        else if (disarmVec[n])  armedQ[n] <= 1'b0;
        else if (fireVec[n])    armedQ[n] <= 1'b0;

        if (fireVec[n])         rawQ[n] <= 1'b1;
        else if (rawClrVec[n])  rawQ[n] <= 1'b0;
      end
    end

    // R2
    fire_sets_raw_chk: assert property (@(posedge clk) disable iff (!rstN)
      fireVec[n] |=> (rawQ[n] && !armedQ[n]));
    // R7
    wr_arms_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.tgtWr[n] |=> armedQ[n]);
    // R4
    disarm_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
      (disarmVec[n] && !strobe.tgtWr[n]) |=> !armedQ[n]);
    // R5
    raw_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (rawQ[n] && !rawClrVec[n]) |=> rawQ[n]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= '0;
      forceQ <= '0;
    end else begin
      if (strobe.enWr)  enQ    <= strobe.wrData[CH_COUNT-1:0];
      if (strobe.frcWr) forceQ <= strobe.wrData[CH_COUNT-1:0];
    end
  end

  assign statusVec = (rawQ & enQ) | forceQ;
  assign irqOut    = statusVec;

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      SEL_TGT:  rdData = targetQ[rdCh];
      SEL_ARM:  rdData = DATA_W'(armedQ);
      SEL_RAW:  rdData = DATA_W'(rawQ);
      SEL_EN:   rdData = DATA_W'(enQ);
      SEL_FRC:  rdData = DATA_W'(forceQ);
      SEL_STAT: rdData = DATA_W'(statusVec);
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/quad_alarm.sv
module quad_alarm
  import quad_alarm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   timeLo,
  input  logic                busWrEn,
  input  logic [7:0]          busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic                lockIn,
  output logic [CH_COUNT-1:0] irqOut
);

  localparam int unsigned CH_IDX_W = (CH_COUNT > 1) ? $clog2(CH_COUNT) : 1;

  qa_strobe_t          strobe;
  qa_rdsel_e           rdSel;
  logic [CH_IDX_W-1:0] rdCh;

  quad_alarm_ctrl #(.ADDR_W(8)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .lockIn    (lockIn),
    .strobe    (strobe),
    .rdSel     (rdSel),
    .rdCh      (rdCh)
  );

  quad_alarm_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .timeLo (timeLo),
    .strobe (strobe),
    .rdSel  (rdSel),
    .rdCh   (rdCh),
    .rdData (busRdData),
    .irqOut (irqOut)
  );

endmodule

// File: tb/quad_alarm_bench.sv
`timescale 1ns/1ps
module quad_alarm_bench;

  localparam logic [7:0] A_TGT0 = 8'h10, A_TGT1 = 8'h14, A_TGT2 = 8'h18, A_TGT3 = 8'h1C;
  localparam logic [7:0] A_ARM = 8'h20, A_RAW = 8'h3C, A_EN = 8'h40, A_FRC = 8'h44, A_STAT = 8'h48;

  logic        clk = 0;
  logic        rstN = 0;
  logic [31:0] timeLo = 0;
  logic        busWrEn = 0;
  logic [7:0]  busAddr = 0;
  logic [31:0] busWrData = 0;
  logic [31:0] busRdData;
  logic        lockIn = 0;
  logic [3:0]  irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    string       tag;
    bit          isIrq;
    logic [31:0] exp;
  } sb_item_t;

  sb_item_t sbq[$];

  always #10 clk = ~clk;

  quad_alarm u_quad_alarm (
    .clk(clk), .rstN(rstN), .timeLo(timeLo), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .lockIn(lockIn), .irqOut(irqOut)
  );

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      sb_item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      act = it.isIrq ? {28'd0, irqOut} : busRdData;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expectReg(input logic [7:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    busAddr = a;
    it.tag = tag; it.isIrq = 0; it.exp = e;
    sbq.push_back(it);
  endtask

  task automatic expectIrq(input logic [3:0] e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    it.tag = tag; it.isIrq = 1; it.exp = {28'd0, e};
    sbq.push_back(it);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busWrEn = 1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 0;
  endtask

  task automatic setTime(input logic [31:0] v);
    @(posedge clk); #1;
    timeLo = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rstN = 1;

    // R9 reset state
    expectReg(A_TGT0, 32'h0, "R9 target0 after reset");
    expectReg(A_ARM,  32'h0, "R9 armed after reset");
    expectReg(A_RAW,  32'h0, "R9 raw after reset");
    expectReg(A_STAT, 32'h0, "R9 status after reset");
    expectReg(8'h04,  32'h0, "R9 unmapped read");
    expectIrq(4'h0, "R9 irq after reset");

    // R1 target write arms
    setTime(32'd100);
    writeReg(A_TGT0, 32'd200);
    expectReg(A_TGT0, 32'd200, "R1 target0 readback");
    expectReg(A_ARM,  32'h1,   "R1 armed after write");

    // R2 fire on equality, raw set but masked
    setTime(32'd200);
    expectReg(A_RAW, 32'h1, "R2 raw set on match");
    expectReg(A_ARM, 32'h0, "R2 self disarm");
    expectIrq(4'h0, "R6 raw not enabled");
    expectReg(A_STAT, 32'h0, "R6 status masked");

    // R5 clear, no re-fire while time still matches
    writeReg(A_RAW, 32'h1);
    idle(2);
    expectReg(A_RAW, 32'h0, "R5 raw cleared and not refired");

    // R6 enable path
    writeReg(A_EN, 32'h1);
    expectIrq(4'h0, "R6 enabled but raw clear");
    writeReg(A_TGT0, 32'd200);
    expectReg(A_RAW, 32'h1, "R2 refire after rearm");
    expectIrq(4'h1, "R6 irq enabled raw");
    expectReg(A_STAT, 32'h1, "R6 status enabled raw");
    writeReg(A_RAW, 32'h1);
    expectIrq(4'h0, "R5 irq drops after clear");

    // R3 one-bit difference
    setTime(32'h0000_0064);
    writeReg(A_TGT1, 32'h8000_0064);
    idle(3);
    expectReg(A_RAW, 32'h0, "R3 no fire on MSB mismatch");
    expectReg(A_ARM, 32'h2, "R3 stays armed");
    setTime(32'h8000_0064);
    expectReg(A_RAW, 32'h2, "R2 channel1 fires");
    writeReg(A_RAW, 32'h2);

    // R4 early disarm
    writeReg(A_TGT2, 32'd300);
    expectReg(A_ARM, 32'h4, "R1 channel2 armed");
    writeReg(A_ARM, 32'h0);
    expectReg(A_ARM, 32'h4, "R4 zero write no effect");
    writeReg(A_ARM, 32'h4);
    expectReg(A_ARM, 32'h0, "R4 disarmed");
    setTime(32'd300);
    idle(2);
    expectReg(A_RAW, 32'h0, "R4 disarmed channel silent");

    // R6 force
    writeReg(A_FRC, 32'h4);
    expectIrq(4'h4, "R6 force drives irq");
    expectReg(A_STAT, 32'h4, "R6 status forced");
    writeReg(A_FRC, 32'h0);
    expectIrq(4'h0, "R6 force released");

    // R7 write on the match edge wins
    setTime(32'd400);
    writeReg(A_TGT3, 32'd500);
    @(posedge clk); #1;
    timeLo = 32'd500;
    busWrEn = 1; busAddr = A_TGT3; busWrData = 32'd600;
    @(posedge clk); #1;
    busWrEn = 0;
    expectReg(A_RAW,  32'h0,    "R7 no fire on write edge");
    expectReg(A_ARM,  32'h8,    "R7 stays armed");
    expectReg(A_TGT3, 32'd600,  "R7 new target kept");
    setTime(32'd600);
    expectReg(A_RAW, 32'h8, "R7 fires at new target");
    writeReg(A_RAW, 32'hF);

    // two channels together
    writeReg(A_TGT0, 32'd700);
    writeReg(A_TGT2, 32'd700);
    setTime(32'd700);
    expectReg(A_RAW, 32'h5, "R2 two channels fire together");
    expectIrq(4'h1, "R6 only enabled channel on irq");

    // R8 lock
    lockIn = 1;
    writeReg(A_EN, 32'hF);
    writeReg(A_TGT1, 32'd800);
    writeReg(A_RAW, 32'h5);
    writeReg(A_FRC, 32'h2);
    expectReg(A_EN,   32'h1,          "R8 enable unchanged");
    expectReg(A_ARM,  32'h0,          "R8 not armed");
    expectReg(A_TGT1, 32'h8000_0064,  "R8 target unchanged");
    expectReg(A_RAW,  32'h5,          "R8 raw unchanged");
    expectReg(A_FRC,  32'h0,          "R8 force unchanged");
    lockIn = 0;
    writeReg(A_EN, 32'hF);
    expectReg(A_EN, 32'hF, "R8 writes resume after unlock");

    idle(2);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule